// File: doc/BRIEF.md
# Frame Identifier Acceptance Filter

This block sits between a byte-level serial receiver and the host's receive-data register. Its job is to decide, for each frame, whether received bytes reach the host. The first byte after start-of-frame is the frame identifier. That identifier indexes a 256-entry acceptance bitmap. If the indexed bit is one, the identifier and every later byte of the frame are placed in the receive-data register and a full flag is raised. If the bit is zero, the whole frame is dropped.

The bitmap is stored as 32 byte-wide rows. The host reaches those rows through a window of four addresses, and a group field in the control register chooses which four rows the window shows. The rows have no reset value, so software must load all of them before it sets the enable bit.

Software can also set a sleep bit. Sleep stops delivery for the rest of the current frame, and the next start-of-frame clears it again.

Top module: `idf_top`

## Requirements
- R1: Control register (host address 0) has these fields: bits [2:0] group, bit 3 window-map, bit 4 enable, bit 5 sleep. With window-map at 1, host addresses 4 to 7 (offset = address minus 4) read and write table row group*4+offset. With window-map at 0, those addresses read as 0 and writes to them are ignored.
- R2: The first byte after start-of-frame is the identifier. It is accepted when bit id[2:0] of table row id[7:3] is 1, so identifier 00h uses row 0 bit 0 and FFh uses row 31 bit 7.
- R3: For an accepted frame, the identifier and each following byte are written to the receive-data register (host address 1 and the rx_data port). rx_full is set on the clock edge that takes the byte.
- R4: For a rejected frame, no byte of the frame is delivered: rx_data keeps its value and rx_full stays clear.
- R5: While the sleep bit is 1, no byte is delivered. The next start-of-frame clears the sleep bit.
- R6: End-of-frame returns the frame state to idle, so bytes arriving after it are not delivered until a new start-of-frame, whose identifier is evaluated again.
- R7: While the enable bit is 0, no byte is delivered and the frame state stays idle.
- R8: A host read of address 1 returns rx_data and clears rx_full, unless a byte is delivered on the same edge, in which case rx_full stays set.
- R9: After reset, the control register, rx_data and rx_full are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sof | input | 1 | Start-of-frame strobe |
| eof | input | 1 | End-of-frame strobe |
| byte_valid | input | 1 | Received byte strobe |
| rx_byte | input | 8 | Received byte |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_addr | input | 3 | Host register address |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data (combinational) |
| rx_data | output | 8 | Receive-data register |
| rx_full | output | 1 | Receive-data full flag |

## Verification
A wrong frame state shows up at the ports as early as the first data byte after the identifier. An identifier that was evaluated wrongly, or a sleep or end-of-frame that was not honoured, either updates rx_data and raises rx_full when it should not, or fails to do so, one edge after the byte strobe. A wrong row or bit index into the table shows up as an identifier that is accepted or rejected wrongly, which is why the corner identifiers and their neighbours are exercised. Window decode errors appear immediately in host read-back.

// File: rtl/idf_pkg.sv
package idf_pkg;
  localparam int BYTE_W  = 8;
  localparam int ID_W    = 8;
  localparam int NBITS   = 1 << ID_W;
  localparam int NROWS   = NBITS / BYTE_W;
  localparam int ROW_W   = $clog2(NROWS);
  localparam int COL_W   = $clog2(BYTE_W);
  localparam int WIN_SZ  = 4;
  localparam int OFF_W   = $clog2(WIN_SZ);
  localparam int GRP_W   = ROW_W - OFF_W;
  localparam int ADDR_W  = 3;

  localparam logic [ADDR_W-1:0] A_CTRL = 3'd0;
  localparam logic [ADDR_W-1:0] A_RXD  = 3'd1;

  localparam int C_MAP   = 3;
  localparam int C_EN    = 4;
  localparam int C_SLEEP = 5;

  typedef enum logic [1:0] {FS_IDLE, FS_WAIT_ID, FS_ACCEPT, FS_REJECT} fstate_t;

  function automatic logic [ROW_W-1:0] id_row(input logic [ID_W-1:0] id);
    return id[ID_W-1:COL_W];
  endfunction

  function automatic logic [COL_W-1:0] id_col(input logic [ID_W-1:0] id);
    return id[COL_W-1:0];
  endfunction

  function automatic logic [ROW_W-1:0] win_row(input logic [GRP_W-1:0] grp,
                                               input logic [OFF_W-1:0] off);
    return {grp, off};
  endfunction

  function automatic logic is_win(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1];
  endfunction
endpackage

// File: rtl/idf_table.sv
module idf_table
  import idf_pkg::*;
(
  input  logic              clk,
  input  logic              wr_en,
  input  logic [ROW_W-1:0]  wr_row,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic [ROW_W-1:0]  rd_row,
  output logic [BYTE_W-1:0] rd_data,
  input  logic [ID_W-1:0]   look_id,
  output logic              look_hit
);
  logic [BYTE_W-1:0] rows [NROWS];

  // rows deliberately carry no reset
  always_ff @(posedge clk) begin
    if (wr_en) rows[wr_row] <= wr_data;
  end

  logic [BYTE_W-1:0] look_row;
  assign rd_data  = rows[rd_row];
  assign look_row = rows[id_row(look_id)];
  assign look_hit = look_row[id_col(look_id)];
endmodule

// File: rtl/idf_regs.sv
module idf_regs
  import idf_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_wr,
  input  logic              host_rd,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [BYTE_W-1:0] host_wdata,
  output logic [BYTE_W-1:0] host_rdata,
  input  logic              sof,
  input  logic [BYTE_W-1:0] rx_data,
  output logic              rd_clr,
  output logic              tbl_wr,
  output logic [ROW_W-1:0]  tbl_row,
  input  logic [BYTE_W-1:0] tbl_rdata,
  output logic              en,
  output logic              sleep
);
  logic [GRP_W-1:0] grp;
  logic             map;
  logic             ctrl_wr;

  assign ctrl_wr = host_wr && host_addr == A_CTRL;
  assign tbl_row = win_row(grp, host_addr[OFF_W-1:0]);
  assign tbl_wr  = host_wr && is_win(host_addr) && map;
  assign rd_clr  = host_rd && host_addr == A_RXD;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      grp <= '0; map <= 1'b0; en <= 1'b0; sleep <= 1'b0;
    end else if (ctrl_wr) begin
      grp   <= host_wdata[GRP_W-1:0];
      map   <= host_wdata[C_MAP];
      en    <= host_wdata[C_EN];
      sleep <= host_wdata[C_SLEEP];
    end else if (sof) begin
      sleep <= 1'b0;
    end
  end

  always_comb begin
    host_rdata = '0;
    if (host_addr == A_CTRL) begin
      host_rdata[GRP_W-1:0] = grp;
      host_rdata[C_MAP]     = map;
      host_rdata[C_EN]      = en;
      host_rdata[C_SLEEP]   = sleep;
    end else if (host_addr == A_RXD) begin
      host_rdata = rx_data;
    end else if (is_win(host_addr) && map) begin
      host_rdata = tbl_rdata;
    end
  end

  // R5
  sleep_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sof && !ctrl_wr) |=> !sleep);
  // R1
  window_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tbl_wr |-> map));
endmodule

// File: rtl/idf_gate.sv
module idf_gate
  import idf_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sof,
  input  logic              eof,
  input  logic              byte_valid,
  input  logic [BYTE_W-1:0] rx_byte,
  input  logic              en,
  input  logic              sleep,
  input  logic              hit,
  input  logic              rd_clr,
  output logic              deliver,
  output fstate_t           fstate,
  output logic [BYTE_W-1:0] rx_data,
  output logic              rx_full
);
  logic take;
  assign take    = byte_valid && !sof && en;
  assign deliver = take && !sleep &&
                   ((fstate == FS_WAIT_ID && hit) || fstate == FS_ACCEPT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fstate <= FS_IDLE;
    else if (!en) fstate <= FS_IDLE;
    else if (sof) fstate <= FS_WAIT_ID;
    else if (eof) fstate <= FS_IDLE;
    else if (take && fstate == FS_WAIT_ID)
      fstate <= hit ? FS_ACCEPT : FS_REJECT;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_data <= '0; rx_full <= 1'b0;
    end else if (deliver) begin
      rx_data <= rx_byte; rx_full <= 1'b1;
    end else if (rd_clr) begin
      rx_full <= 1'b0;
    end
  end

  // R3
  deliver_sets_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    deliver |=> (rx_full && rx_data == $past(rx_byte)));
  // R4
  reject_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fstate == FS_REJECT) |-> !deliver);
  // R7
  disabled_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (fstate == FS_IDLE));
  // R6
  eof_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eof && !sof) |=> (fstate == FS_IDLE));
  // R8
  read_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_clr && !deliver) |=> !rx_full);
endmodule

// File: rtl/idf_top.sv
module idf_top
  import idf_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         sof,
  input  logic         eof,
  input  logic         byte_valid,
  input  logic [7:0]   rx_byte,
  input  logic         host_wr,
  input  logic         host_rd,
  input  logic [2:0]   host_addr,
  input  logic [7:0]   host_wdata,
  output logic [7:0]   host_rdata,
  output logic [7:0]   rx_data,
  output logic         rx_full
);
  logic              rd_clr, tbl_wr, en, sleep, hit, deliver;
  logic [ROW_W-1:0]  tbl_row;
  logic [BYTE_W-1:0] tbl_rdata;
  fstate_t           fstate;

  idf_regs regs_i (
    .clk, .rst_n, .host_wr, .host_rd, .host_addr, .host_wdata, .host_rdata,
    .sof, .rx_data, .rd_clr, .tbl_wr, .tbl_row, .tbl_rdata, .en, .sleep
  );

  idf_table table_i (
    .clk, .wr_en(tbl_wr), .wr_row(tbl_row), .wr_data(host_wdata),
    .rd_row(tbl_row), .rd_data(tbl_rdata), .look_id(rx_byte), .look_hit(hit)
  );

  idf_gate gate_i (
    .clk, .rst_n, .sof, .eof, .byte_valid, .rx_byte, .en, .sleep, .hit,
    .rd_clr, .deliver, .fstate, .rx_data, .rx_full
  );

  // R2
  id_verdict_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fstate == FS_WAIT_ID && byte_valid && !sof && en && !eof) |=>
      (fstate == ($past(hit) ? FS_ACCEPT : FS_REJECT)));
  // R5
  sleep_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |-> !deliver);
endmodule

// File: tb/idf_top_tb_top.sv
module idf_top_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sof = 0, eof = 0, byte_valid = 0, host_wr = 0, host_rd = 0;
  logic [7:0] rx_byte = 0, host_wdata = 0;
  logic [2:0] host_addr = 0;
  logic [7:0] host_rdata, rx_data;
  logic rx_full;

  int checks = 0, fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  idf_top dut_i (.*);

  function automatic bit accept_of(input logic [7:0] id);
    return (id % 3 == 0);
  endfunction

  function automatic logic [7:0] row_image(input int r);
    logic [7:0] v;
    for (int b = 0; b < 8; b++) v[b] = accept_of(8'(r*8 + b));
    return v;
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic hwrite(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); host_wr = 1; host_addr = a; host_wdata = d;
    @(negedge clk); host_wr = 0;
  endtask

  task automatic hread(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); host_rd = 1; host_addr = a; #1 d = host_rdata;
    @(negedge clk); host_rd = 0;
  endtask

  task automatic strobe_sof;
    @(negedge clk); sof = 1; @(negedge clk); sof = 0;
  endtask
  task automatic strobe_eof;
    @(negedge clk); eof = 1; @(negedge clk); eof = 0;
  endtask
  task automatic put_byte(input logic [7:0] b);
    @(negedge clk); byte_valid = 1; rx_byte = b;
    @(negedge clk); byte_valid = 0;
  endtask

  task automatic clear_full;
    logic [7:0] d;
    hread(3'd1, d);
  endtask

  // ctrl: [2:0] group, [3] map, [4] enable, [5] sleep
  task automatic load_table;
    for (int g = 0; g < 8; g++) begin
      hwrite(3'd0, 8'(8 | g));
      for (int o = 0; o < 4; o++) hwrite(3'(4 + o), row_image(g*4 + o));
    end
  endtask

  task automatic t_reset;
    logic [7:0] d;
    chk("R9 rx_full", {7'b0, rx_full}, 8'h00);
    chk("R9 rx_data", rx_data, 8'h00);
    hread(3'd0, d); chk("R9 ctrl", d, 8'h00);
  endtask

  task automatic t_window;
    logic [7:0] d;
    hwrite(3'd0, 8'h0B);            // group 3, map on
    hread(3'd6, d); chk("R1 row14 readback", d, row_image(14));
    hwrite(3'd0, 8'h0F);
    hread(3'd7, d); chk("R1 row31 readback", d, row_image(31));
    hwrite(3'd0, 8'h07);            // map off
    hread(3'd7, d); chk("R1 unmapped read", d, 8'h00);
    hwrite(3'd7, 8'hA5);            // must be ignored
    hwrite(3'd0, 8'h0F);
    hread(3'd7, d); chk("R1 unmapped write ignored", d, row_image(31));
  endtask

  task automatic t_accept;
    hwrite(3'd0, 8'h10);            // enable
    strobe_sof; put_byte(8'h00);
    chk("R2 id 00 accepted", rx_data, 8'h00);
    chk("R3 full after id", {7'b0, rx_full}, 8'h01);
    put_byte(8'h5C); chk("R3 data byte", rx_data, 8'h5C);
    strobe_eof; clear_full;
    strobe_sof; put_byte(8'hFF);
    chk("R2 id FF accepted", rx_data, 8'hFF);
    put_byte(8'h12); chk("R3 second frame data", rx_data, 8'h12);
    strobe_eof; clear_full;
  endtask

  task automatic t_reject;
    strobe_sof; put_byte(8'hFE);
    chk("R4 id FE dropped", rx_data, 8'h12);
    chk("R4 full clear", {7'b0, rx_full}, 8'h00);
    put_byte(8'h33); chk("R4 data dropped", rx_data, 8'h12);
    strobe_eof;
    strobe_sof; put_byte(8'h01);
    chk("R2 id 01 rejected", {7'b0, rx_full}, 8'h00);
    strobe_eof;
  endtask

  task automatic t_sleep;
    logic [7:0] d;
    strobe_sof; put_byte(8'h03);
    chk("R3 id 03", rx_data, 8'h03);
    clear_full;
    hwrite(3'd0, 8'h30);            // enable + sleep
    put_byte(8'h77);
    chk("R5 sleep drops", rx_data, 8'h03);
    chk("R5 full clear", {7'b0, rx_full}, 8'h00);
    strobe_eof; strobe_sof;
    hread(3'd0, d); chk("R5 sleep cleared by sof", d, 8'h10);
    put_byte(8'h06); chk("R5 resumed", rx_data, 8'h06);
    strobe_eof; clear_full;
  endtask

  task automatic t_eof;
    strobe_sof; put_byte(8'h09); strobe_eof; clear_full;
    put_byte(8'h44);
    chk("R6 after eof dropped", {7'b0, rx_full}, 8'h00);
    strobe_sof; put_byte(8'h04);
    chk("R6 new id evaluated", {7'b0, rx_full}, 8'h00);
    strobe_eof;
  endtask

  task automatic t_disable;
    hwrite(3'd0, 8'h00);
    strobe_sof; put_byte(8'h0C); put_byte(8'h21);
    chk("R7 disabled no delivery", {7'b0, rx_full}, 8'h00);
    chk("R7 data kept", rx_data, 8'h09);
    hwrite(3'd0, 8'h10);
    put_byte(8'h0C);
    chk("R7 idle after enable", {7'b0, rx_full}, 8'h00);
  endtask

  task automatic t_read_clear;
    logic [7:0] d;
    strobe_sof; put_byte(8'h0F);
    chk("R8 full set", {7'b0, rx_full}, 8'h01);
    hread(3'd1, d);
    chk("R8 read data", d, 8'h0F);
    chk("R8 read clears", {7'b0, rx_full}, 8'h00);
    // read and delivery on the same edge
    @(negedge clk); host_rd = 1; host_addr = 3'd1; byte_valid = 1; rx_byte = 8'h66;
    @(negedge clk); host_rd = 0; byte_valid = 0;
    chk("R8 delivery wins", {7'b0, rx_full}, 8'h01);
    chk("R8 delivered byte", rx_data, 8'h66);
    strobe_eof;
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset;
    load_table;
    t_window;
    t_accept;
    t_reject;
    t_sleep;
    t_eof;
    t_disable;
    t_read_clear;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule